// File: doc/BRIEF.md
# Split-Read Event Counter

This block is a binary up-counter, twice a byte wide, that software reaches over a small register bus as two byte registers: the low byte at an even base address and the high byte at the address above it. The counter advances by one on every clock in which the run control is on and the count tick is high. It rolls over from all ones to zero and flags each rollover with a single-cycle pulse.

Software has two ways to get a coherent value. A word read at the low address returns both halves taken in the same cycle. Byte reads also stay coherent. Reading the low byte copies the live high byte into a shadow register, and a later high-byte read returns that copy, so a carry between the two reads does not tear the value.

Any accepted write clears the counter, whatever the data. Writes are meant to happen only while the counter is stopped. A write that arrives while the run control, the trigger-enable control or the busy status input is active still clears the counter, and it also sets a sticky warning flag.

Top module: `split_read_counter`

## Requirements
- R1: After a synchronous reset the counter, the shadow register, the read data, the read-valid strobe, the rollover pulse and the warning flag are all zero.
- R2: The counter rises by exactly one in each cycle in which `run_i` and `cnt_tick_i` are both high. In every other cycle with no write it holds its value.
- R3: An increment from the all-ones value gives zero, and `ovf_o` is high for exactly the one cycle in which the counter first shows zero after that increment.
- R4: An accepted write clears the whole counter to zero. Accepted writes are a byte or word write at the low address and a byte write at the high address. The write data has no effect.
- R5: When a clearing write and an increment fall in the same cycle, the counter becomes zero and `ovf_o` stays low.
- R6: An accepted write while any of `run_i`, `trig_en_i` or `stat_i` is high sets `wr_run_flag_o`. Only reset clears it.
- R7: A byte read at the low address returns the live low byte in bits [BYTE_W-1:0] of `bus_rdata_o`, with the upper bits zero. It also copies the live high byte into the shadow register.
- R8: A byte read at the high address returns the shadow register in bits [BYTE_W-1:0] and never the live high byte. With no earlier low read since reset, it returns zero.
- R9: A word read at the low address returns {live high byte, live low byte}, both from the same cycle. It also loads the shadow register as a low read does.
- R10: A word access at the high address is ignored: no read strobe follows it, and a word write there does not clear the counter.
- R11: Read data and `bus_rvalid_o` appear in the cycle after the accepted read request. The data reflects the counter as it was before that edge's update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run_i | input | 1 | Run control; counting is allowed while high |
| trig_en_i | input | 1 | Trigger-enable control; used only to qualify writes |
| stat_i | input | 1 | Busy status; used only to qualify writes |
| cnt_tick_i | input | 1 | Count-enable tick, synchronous to clk |
| bus_req_i | input | 1 | Bus access request, one cycle per access |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_word_i | input | 1 | 1 = word access, 0 = byte access |
| bus_addr_i | input | ADDR_W | Access address |
| bus_wdata_i | input | 2*BYTE_W | Write data (ignored) |
| bus_rdata_o | output | 2*BYTE_W | Registered read data |
| bus_rvalid_o | output | 1 | Read data valid strobe |
| ovf_o | output | 1 | One-cycle rollover pulse |
| wr_run_flag_o | output | 1 | Sticky flag for a write while not stopped |

## Verification
The bench builds the block with BYTE_W = 4, ADDR_W = 4 and BASE_ADDR = 2, so the counter is 8 bits wide and rolls over after 256 ticks. That makes the rollover pulse and a carry from the low nibble into the high nibble cheap to reach many times in one run. Placing the base at a nonzero even address also checks that the decoder compares the full address, not just its lowest bit.

// File: rtl/split_read_counter_pkg.sv
package split_read_counter_pkg;

  // kind of read access seen by the read path in a given cycle
  typedef enum logic [1:0] {
    RD_NONE = 2'd0,
    RD_LO   = 2'd1,
    RD_HI   = 2'd2,
    RD_WORD = 2'd3
  } rd_kind_e;

endpackage

// File: rtl/src_decode.sv
module src_decode
  import split_read_counter_pkg::*;
#(
  parameter int ADDR_W    = 4,
  parameter int BASE_ADDR = 0
) (
  input  logic              req_i,
  input  logic              we_i,
  input  logic              word_i,
  input  logic [ADDR_W-1:0] addr_i,
  output rd_kind_e          rd_kind_o,
  output logic              clr_o
);

  localparam logic [ADDR_W-1:0] LO_ADDR = ADDR_W'(BASE_ADDR);
  localparam logic [ADDR_W-1:0] HI_ADDR = ADDR_W'(BASE_ADDR + 1);

  logic hit_lo, hit_hi;

  always_comb begin
    hit_lo = req_i && (addr_i == LO_ADDR);
    hit_hi = req_i && (addr_i == HI_ADDR) && !word_i;
    clr_o  = (hit_lo || hit_hi) && we_i;
    rd_kind_o = RD_NONE;
    if (!we_i) begin
      if (hit_lo)      rd_kind_o = word_i ? RD_WORD : RD_LO;
      else if (hit_hi) rd_kind_o = RD_HI;
    end
  end

endmodule

// File: rtl/src_core.sv
module src_core #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_o
);

  localparam logic [CNT_W-1:0] ALL_ONES = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;
  logic             ovf_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      ovf_q <= inc_i && !clr_i && (cnt_q == ALL_ONES);
      if (clr_i)      cnt_q <= '0;
      else if (inc_i) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign cnt_o = cnt_q;
  assign ovf_o = ovf_q;

  // R2
  inc_step_chk: assert property (@(posedge clk) disable iff (rst)
    (inc_i && !clr_i) |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1)));

  // R2
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!inc_i && !clr_i) |=> $stable(cnt_q));

  // R5
  clr_wins_chk: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> (cnt_q == '0 && !ovf_q));

  // R3
  ovf_zero_chk: assert property (@(posedge clk) disable iff (rst)
    ovf_q |-> (cnt_q == '0));

  // R3
  ovf_single_chk: assert property (@(posedge clk) disable iff (rst)
    ovf_q |=> !ovf_q);

endmodule

// File: rtl/src_rdpath.sv
module src_rdpath
  import split_read_counter_pkg::*;
#(
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  rd_kind_e            rd_kind_i,
  input  logic [2*BYTE_W-1:0] cnt_i,
  output logic [2*BYTE_W-1:0] rdata_o,
  output logic                rvalid_o
);

  localparam int LANES = 2;

  logic [BYTE_W-1:0]         shadow_q;
  logic [2*BYTE_W-1:0]       rdata_d;
  logic [2*BYTE_W-1:0]       rdata_q;
  logic                      rvalid_q;
  logic                      capture;

  assign capture = (rd_kind_i == RD_LO) || (rd_kind_i == RD_WORD);

  // one mux per byte lane of the returned word
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    if (g == 0) begin : g_low
      always_comb begin
        case (rd_kind_i)
          RD_LO, RD_WORD: rdata_d[BYTE_W-1:0] = cnt_i[BYTE_W-1:0];
          RD_HI:          rdata_d[BYTE_W-1:0] = shadow_q;
          default:        rdata_d[BYTE_W-1:0] = '0;
        endcase
      end
    end else begin : g_high
      always_comb begin
        if (rd_kind_i == RD_WORD) rdata_d[2*BYTE_W-1:BYTE_W] = cnt_i[2*BYTE_W-1:BYTE_W];
        else                      rdata_d[2*BYTE_W-1:BYTE_W] = '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow_q <= '0;
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= (rd_kind_i != RD_NONE);
      if (rd_kind_i != RD_NONE) rdata_q <= rdata_d;
      if (capture) shadow_q <= cnt_i[2*BYTE_W-1:BYTE_W];
    end
  end

  assign rdata_o  = rdata_q;
  assign rvalid_o = rvalid_q;

  // R8
  shadow_keep_chk: assert property (@(posedge clk) disable iff (rst)
    !capture |=> $stable(shadow_q));

  // R7
  byte_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_kind_i == RD_LO || rd_kind_i == RD_HI) |=> (rdata_q[2*BYTE_W-1:BYTE_W] == '0));

  // R9
  word_live_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_kind_i == RD_WORD) |=> (rdata_q == $past(cnt_i)));

endmodule

// File: rtl/split_read_counter.sv
module split_read_counter
  import split_read_counter_pkg::*;
#(
  parameter int BYTE_W    = 8,
  parameter int ADDR_W    = 4,
  parameter int BASE_ADDR = 0
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                run_i,
  input  logic                trig_en_i,
  input  logic                stat_i,
  input  logic                cnt_tick_i,
  input  logic                bus_req_i,
  input  logic                bus_we_i,
  input  logic                bus_word_i,
  input  logic [ADDR_W-1:0]   bus_addr_i,
  input  logic [2*BYTE_W-1:0] bus_wdata_i,
  output logic [2*BYTE_W-1:0] bus_rdata_o,
  output logic                bus_rvalid_o,
  output logic                ovf_o,
  output logic                wr_run_flag_o
);

  localparam int CNT_W = 2 * BYTE_W;
  localparam logic [ADDR_W-1:0] HI_ADDR = ADDR_W'(BASE_ADDR + 1);

  rd_kind_e          rd_kind;
  logic              clr;
  logic              inc;
  logic [CNT_W-1:0]  cnt;
  logic              flag_q;
  logic              active;
  logic              unused_wdata;

  assign unused_wdata = ^bus_wdata_i;
  assign inc    = run_i && cnt_tick_i;
  assign active = run_i || trig_en_i || stat_i;

  src_decode #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_dec (
    .req_i     (bus_req_i),
    .we_i      (bus_we_i),
    .word_i    (bus_word_i),
    .addr_i    (bus_addr_i),
    .rd_kind_o (rd_kind),
    .clr_o     (clr)
  );

  src_core #(.CNT_W(CNT_W)) u_core (
    .clk   (clk),
    .rst   (rst),
    .clr_i (clr),
    .inc_i (inc),
    .cnt_o (cnt),
    .ovf_o (ovf_o)
  );

  src_rdpath #(.BYTE_W(BYTE_W)) u_rd (
    .clk       (clk),
    .rst       (rst),
    .rd_kind_i (rd_kind),
    .cnt_i     (cnt),
    .rdata_o   (bus_rdata_o),
    .rvalid_o  (bus_rvalid_o)
  );

  always_ff @(posedge clk) begin
    if (rst)                flag_q <= 1'b0;
    else if (clr && active) flag_q <= 1'b1;
  end

  assign wr_run_flag_o = flag_q;

  // R6
  flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    wr_run_flag_o |=> wr_run_flag_o);

  // R6
  flag_set_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_req_i && bus_we_i && active && rd_kind == RD_NONE && clr) |=> wr_run_flag_o);

  // R10
  hi_word_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_req_i && bus_word_i && bus_addr_i == HI_ADDR) |=> !bus_rvalid_o);

  // R11
  rvalid_needs_req_chk: assert property (@(posedge clk) disable iff (rst)
    bus_rvalid_o |-> $past(bus_req_i && !bus_we_i));

endmodule

// File: tb/split_read_counter_tb.sv
module split_read_counter_tb_top;

  localparam int BW   = 4;
  localparam int CW   = 2 * BW;
  localparam int AW   = 4;
  localparam int BASE = 2;
  localparam logic [AW-1:0] LO = 4'd2;
  localparam logic [AW-1:0] HI = 4'd3;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          run = 1'b0, trig = 1'b0, stat = 1'b0, tick = 1'b0;
  logic          req = 1'b0, we = 1'b0, word = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [CW-1:0] wdata = '0;
  logic [CW-1:0] rdata;
  logic          rvalid, ovf, flag;

  int n_tests = 0;
  int n_fail  = 0;

  // reference model state
  logic [CW-1:0] m_cnt;
  logic [BW-1:0] m_sh;
  logic          m_ovf, m_flag;

  logic [CW-1:0] exp_q[$];
  string         tag_q[$];

  always #2 clk = ~clk;

  split_read_counter #(.BYTE_W(BW), .ADDR_W(AW), .BASE_ADDR(BASE)) dut_i (
    .clk(clk), .rst(rst), .run_i(run), .trig_en_i(trig), .stat_i(stat),
    .cnt_tick_i(tick), .bus_req_i(req), .bus_we_i(we), .bus_word_i(word),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .bus_rvalid_o(rvalid), .ovf_o(ovf), .wr_run_flag_o(flag)
  );

  always @(posedge clk) begin : ref_model
    logic lo_hit, hi_hit, clr_b, inc_b;
    if (rst) begin
      m_cnt <= '0; m_sh <= '0; m_ovf <= 1'b0; m_flag <= 1'b0;
    end else begin
      lo_hit = req && addr == LO;
      hi_hit = req && addr == HI && !word;
      clr_b  = (lo_hit || hi_hit) && we;
      inc_b  = run && tick;
      m_ovf <= inc_b && !clr_b && m_cnt == {CW{1'b1}};
      if (clr_b)      m_cnt <= '0;
      else if (inc_b) m_cnt <= m_cnt + 1'b1;
      if (lo_hit && !we) m_sh <= m_cnt[CW-1:BW];
      if (clr_b && (run || trig || stat)) m_flag <= 1'b1;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst) begin
      if (rvalid) begin
        if (exp_q.size() == 0) begin
          chk("R10 unexpected read strobe", 32'(rvalid), 32'd0);
        end else begin
          chk(tag_q.pop_front(), 32'(rdata), 32'(exp_q.pop_front()));
        end
      end
      if (ovf || m_ovf) chk("R3 rollover pulse", 32'(ovf), 32'(m_ovf));
      else if (ovf !== m_ovf) chk("R3 rollover pulse", 32'(ovf), 32'(m_ovf));
    end
  end

  // driver: one access, expected value queued from model state
  task automatic access(input logic [AW-1:0] a, input logic w, input logic wr,
                        input string tag);
    req = 1'b1; we = wr; word = w; addr = a; wdata = 8'hA5;
    if (!wr) begin
      if (a == LO) begin
        exp_q.push_back(w ? m_cnt : {{BW{1'b0}}, m_cnt[BW-1:0]});
        tag_q.push_back(tag);
      end else if (a == HI && !w) begin
        exp_q.push_back({{BW{1'b0}}, m_sh});
        tag_q.push_back(tag);
      end
    end
    @(negedge clk);
    req = 1'b0; we = 1'b0; word = 1'b0;
  endtask

  task automatic ticks(input int n);
    run = 1'b1; tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1; run = 1'b0; trig = 1'b0; stat = 1'b0; tick = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk);
    do_reset();
    // R1 reset state
    chk("R1 rdata", 32'(rdata), 0);
    chk("R1 rvalid", 32'(rvalid), 0);
    chk("R1 ovf", 32'(ovf), 0);
    chk("R1 flag", 32'(flag), 0);
    // R8 high read before any low read returns reset shadow
    access(HI, 1'b0, 1'b0, "R8 shadow after reset");
    access(LO, 1'b1, 1'b0, "R9 word after reset");
    // R2 counting and run gating
    ticks(5);
    access(LO, 1'b1, 1'b0, "R2 word after 5 ticks");
    run = 1'b0; tick = 1'b1;
    repeat (4) @(negedge clk);
    tick = 1'b0;
    access(LO, 1'b0, 1'b0, "R2 no count while stopped");
    // R11 read during a tick returns pre-update value
    run = 1'b1; tick = 1'b1;
    access(LO, 1'b1, 1'b0, "R11 read with concurrent tick");
    tick = 1'b0;
    // R7 R8 split read across low-to-high carry
    ticks(9);
    access(LO, 1'b0, 1'b0, "R7 low byte before carry");
    ticks(1);
    access(HI, 1'b0, 1'b0, "R8 high byte is shadow not live");
    access(LO, 1'b1, 1'b0, "R9 live word after carry");
    access(HI, 1'b0, 1'b0, "R9 word read loaded shadow");
    // R3 rollover
    ticks(int'(8'hFF - 8'h10));
    access(LO, 1'b1, 1'b0, "R3 all ones before wrap");
    ticks(1);
    chk("R3 ovf after wrap", 32'(ovf), 1);
    @(negedge clk);
    chk("R3 ovf single cycle", 32'(ovf), 0);
    access(LO, 1'b1, 1'b0, "R3 zero after wrap");
    // R4 clear while stopped, byte low and byte high
    run = 1'b0; trig = 1'b0; stat = 1'b0;
    ticks(3); run = 1'b0;
    access(LO, 1'b0, 1'b1, "R4 write low");
    access(LO, 1'b1, 1'b0, "R4 cleared by low write");
    chk("R6 no flag when stopped", 32'(flag), 0);
    ticks(7); run = 1'b0;
    access(HI, 1'b0, 1'b1, "R4 write high");
    access(LO, 1'b1, 1'b0, "R4 cleared by high write");
    ticks(2); run = 1'b0;
    access(LO, 1'b1, 1'b1, "R4 word write low");
    access(LO, 1'b1, 1'b0, "R4 cleared by word write");
    chk("R6 flag still clear", 32'(flag), 0);
    // R10 word access at high address ignored
    ticks(6); run = 1'b0;
    access(HI, 1'b1, 1'b0, "R10 word read high");
    access(HI, 1'b1, 1'b1, "R10 word write high");
    @(negedge clk);
    access(LO, 1'b1, 1'b0, "R10 count kept after high word write");
    chk("R10 flag untouched", 32'(flag), 0);
    // R5 clear beats concurrent increment; R6 flag set
    ticks(4);
    run = 1'b1; tick = 1'b1;
    access(LO, 1'b0, 1'b1, "R5 write with tick");
    tick = 1'b0; run = 1'b0;
    access(LO, 1'b1, 1'b0, "R5 clear wins");
    chk("R6 flag after write while running", 32'(flag), 32'(m_flag));
    chk("R6 flag set", 32'(flag), 1);
    repeat (3) @(negedge clk);
    chk("R6 flag sticky", 32'(flag), 1);
    // R6 trigger-enable and status also qualify
    do_reset();
    chk("R1 flag cleared by reset", 32'(flag), 0);
    trig = 1'b1;
    access(HI, 1'b0, 1'b1, "R6 write with trigger enable");
    trig = 1'b0;
    chk("R6 flag via trigger enable", 32'(flag), 1);
    do_reset();
    stat = 1'b1;
    access(LO, 1'b0, 1'b1, "R6 write with status");
    stat = 1'b0;
    chk("R6 flag via status", 32'(flag), 1);
    repeat (3) @(negedge clk);
    chk("R11 scoreboard drained", 32'(exp_q.size()), 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule